// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Status

This block is a 16-entry translation cache that maps 4 KB virtual pages to physical frames. Each entry pairs a virtual page number tag with a page table entry. The entry holds a 20-bit frame number, a 2-bit protection code and three flags: valid, referenced and modified. A lookup compares the page number of the presented virtual address against every tag at once, in the same cycle. On a hit the block returns the physical address, checks the requested kind of access against the protection code, and sets the entry's status flags at the next clock edge. On a miss it raises a miss flag.

Page table walking lies outside the block. After a miss, the surrounding logic supplies the missing entry on the refill port. The refill lands in an empty slot when one exists. When every slot is occupied, it lands in the slot named by a round-robin pointer. System software keeps the cache consistent with memory through two operations: it removes a single page's entry when that page's rights change, and it empties the whole cache when the address space changes.

Top module: `tlb_assoc`

## Requirements
- R1: A lookup hits when any valid entry's tag equals lookup address bits [31:12]. lk_hit and lk_miss are combinational in the same cycle, and exactly one of them is high while lk_valid is high.
- R2: On a hit, lk_paddr equals the stored frame number in bits [31:12] and lookup address bits [11:0] in bits [11:0]. Without a hit, lk_paddr is zero.
- R3: An entry whose valid flag is clear never hits. After reset, every lookup misses.
- R4: Protection code 0 allows nothing, code 1 allows read, code 2 allows read and write, and code 3 allows read and execute. The access kind is 0 for read, 1 for write, 2 for execute and 3 for reserved; reserved is never allowed. lk_fault is high when a hit requests an access that its code does not allow.
- R5: An allowed hit sets the entry's referenced flag at the next clock edge. The modified flag is set only when the allowed hit is a write.
- R6: A faulting hit leaves both status flags unchanged.
- R7: A refill stores the given page number, frame number and protection code with valid set and both status flags clear. The entry can be hit from the next cycle on.
- R8: A refill goes to the lowest-numbered slot whose valid flag is clear.
- R9: When all slots are valid, a refill replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping at 16, on every refill that takes effect, whichever slot that refill fills.
- R10: An invalidate clears the valid flag of the entry tagged with the given page number and leaves every other entry intact.
- R11: A flush clears every valid flag. A refill in the same cycle as a flush is discarded and does not advance the pointer.
- R12: lk_ref and lk_mod report the hit entry's stored status flags as they are before the current access updates them. Both read zero on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_miss | output | 1 | Lookup matched no valid entry |
| lk_fault | output | 1 | Hit with an access that the protection code forbids |
| lk_paddr | output | 32 | Translated physical address |
| lk_ref | output | 1 | Stored referenced flag of the hit entry |
| lk_mod | output | 1 | Stored modified flag of the hit entry |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 20 | Page number of the refill |
| fill_pfn | input | 20 | Frame number of the refill |
| fill_prot | input | 2 | Protection code of the refill |
| inv_valid | input | 1 | Single-entry invalidate request |
| inv_vpn | input | 20 | Page number to invalidate |
| flush | input | 1 | Invalidate all entries |

## Verification
The bound checker watches several properties on every cycle. At most one entry matches at a time. Hit and miss are mutually exclusive and always cover a request. A fault only ever comes with a hit. After a flush, nothing hits. A refilled page hits on the next cycle. After an allowed write, the same address shows both status flags set. Other behaviours need the bench's scripted sequences: the full protection matrix against the expected fault pattern, the flags staying clear after faulting accesses, empty-slot-first placement, the round-robin eviction order across pointer wrap, and the precedence of a flush over a refill in the same cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PFN_W  = 20;
  localparam int PA_W   = PFN_W + OFF_W;
  localparam int PROT_W = 2;
  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_kind_e;

  typedef enum logic [PROT_W-1:0] {
    PR_NONE = 2'd0,
    PR_RO   = 2'd1,
    PR_RW   = 2'd2,
    PR_RX   = 2'd3
  } prot_e;

  typedef struct packed {
    logic [PFN_W-1:0]  pfn;
    logic [PROT_W-1:0] prot;
    logic              v;
    logic              r;
    logic              m;
  } pte_t;
endpackage

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  logic [PROT_W-1:0] prot,
  input  logic [KIND_W-1:0] kind,
  output logic              allow
);
  always_comb begin
    allow = 1'b0;
    unique case (prot)
      PR_NONE: allow = 1'b0;
      PR_RO:   allow = (kind == ACC_RD);
      PR_RW:   allow = (kind == ACC_RD) || (kind == ACC_WR);
      PR_RX:   allow = (kind == ACC_RD) || (kind == ACC_EX);
      default: allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  pte_t             wr_pte,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             upd_en,
  input  logic             upd_wr,
  output logic             hit,
  output logic             vld,
  output pte_t             pte
);
  logic [VPN_W-1:0] tag_q, tag_d;
  pte_t             pte_q, pte_d;
  logic             inv_hit;
  logic             ce;

  assign inv_hit = inv_en && pte_q.v && (tag_q == inv_vpn);
  assign ce      = flush || wr_en || inv_hit || upd_en;

  always_comb begin
    tag_d = tag_q;
    pte_d = pte_q;
    if (flush) begin
      pte_d.v = 1'b0;
    end else if (wr_en) begin
      tag_d = wr_vpn;
      pte_d = wr_pte;
    end else if (inv_hit) begin
      pte_d.v = 1'b0;
    end else if (upd_en) begin
      pte_d.r = 1'b1;
      if (upd_wr) pte_d.m = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      pte_q <= '0;
    end else if (ce) begin
      tag_q <= tag_d;
      pte_q <= pte_d;
    end
  end

  assign hit = pte_q.v && (tag_q == lk_vpn);
  assign vld = pte_q.v;
  assign pte = pte_q;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ENT-1:0] valid_vec,
  input  logic             fill_en,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign victim = any_free ? free_idx : rr_q;
  assign rr_d   = (rr_q == IDX_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (fill_en) begin
      rr_q <= rr_d;
    end
  end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [KIND_W-1:0] lk_kind,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_fault,
  output logic [PA_W-1:0]   lk_paddr,
  output logic              lk_ref,
  output logic              lk_mod,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PROT_W-1:0] fill_prot,
  input  logic              inv_valid,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic              flush
);
  localparam int IDX_W = $clog2(N_ENT);

  logic [N_ENT-1:0] hit_vec;
  logic [N_ENT-1:0] valid_vec;
  pte_t             pte_arr [N_ENT];
  pte_t             sel_pte;
  pte_t             fill_pte;
  logic [VPN_W-1:0] lk_vpn;
  logic [IDX_W-1:0] victim;
  logic             fill_en;
  logic             any_hit;
  logic             allow;
  logic             upd_ok;

  assign lk_vpn  = lk_vaddr[VA_W-1:OFF_W];
  assign fill_en = fill_valid && !flush;

  always_comb begin
    fill_pte      = '0;
    fill_pte.pfn  = fill_pfn;
    fill_pte.prot = fill_prot;
    fill_pte.v    = 1'b1;
  end

  tlb_victim #(.N_ENT(N_ENT)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .fill_en   (fill_en),
    .victim    (victim)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    tlb_entry u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_en   (fill_en && (victim == IDX_W'(g))),
      .wr_vpn  (fill_vpn),
      .wr_pte  (fill_pte),
      .inv_en  (inv_valid),
      .inv_vpn (inv_vpn),
      .lk_vpn  (lk_vpn),
      .upd_en  (upd_ok && hit_vec[g]),
      .upd_wr  (lk_kind == ACC_WR),
      .hit     (hit_vec[g]),
      .vld     (valid_vec[g]),
      .pte     (pte_arr[g])
    );
  end

  always_comb begin
    sel_pte = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (hit_vec[i]) sel_pte = sel_pte | pte_arr[i];
    end
  end

  tlb_perm u_perm (
    .prot  (sel_pte.prot),
    .kind  (lk_kind),
    .allow (allow)
  );

  assign any_hit  = |hit_vec;
  assign lk_hit   = lk_valid && any_hit;
  assign lk_miss  = lk_valid && !any_hit;
  assign lk_fault = lk_hit && !allow;
  assign upd_ok   = lk_hit && allow;
  assign lk_paddr = lk_hit ? {sel_pte.pfn, lk_vaddr[OFF_W-1:0]} : '0;
  assign lk_ref   = lk_hit && sel_pte.r;
  assign lk_mod   = lk_hit && sel_pte.m;
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk
  import tlb_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [VA_W-1:0]   lk_vaddr,
  input logic [KIND_W-1:0] lk_kind,
  input logic              lk_hit,
  input logic              lk_miss,
  input logic              lk_fault,
  input logic              lk_ref,
  input logic              lk_mod,
  input logic              fill_valid,
  input logic [VPN_W-1:0]  fill_vpn,
  input logic              inv_valid,
  input logic              flush,
  input logic [N_ENT-1:0]  hit_vec
);
  // R1
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R1
  hit_xor_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit != lk_miss));

  // R4
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  // R11
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  // R7
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush && !inv_valid)
    ##1 (lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)) |-> lk_hit);

  // R5
  write_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_hit && !lk_fault && lk_kind == ACC_WR && !flush && !inv_valid && !fill_valid)
    ##1 (lk_valid && lk_vaddr == $past(lk_vaddr)) |-> (lk_hit && lk_ref && lk_mod));
endmodule

bind tlb_assoc tlb_assoc_chk #(.N_ENT(N_ENT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_vaddr   (lk_vaddr),
  .lk_kind    (lk_kind),
  .lk_hit     (lk_hit),
  .lk_miss    (lk_miss),
  .lk_fault   (lk_fault),
  .lk_ref     (lk_ref),
  .lk_mod     (lk_mod),
  .fill_valid (fill_valid),
  .fill_vpn   (fill_vpn),
  .inv_valid  (inv_valid),
  .flush      (flush),
  .hit_vec    (hit_vec)
);

// File: tb/tb_tlb_assoc.sv
module tb_tlb_assoc;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_kind;
  logic        lk_hit, lk_miss, lk_fault, lk_ref, lk_mod;
  logic [31:0] lk_paddr;
  logic        fill_valid;
  logic [19:0] fill_vpn, fill_pfn;
  logic [1:0]  fill_prot;
  logic        inv_valid;
  logic [19:0] inv_vpn;
  logic        flush;

  int checks = 0;
  int errors = 0;
  int rr     = 0;

  tlb_assoc dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
    .lk_paddr(lk_paddr), .lk_ref(lk_ref), .lk_mod(lk_mod),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_prot(fill_prot), .inv_valid(inv_valid), .inv_vpn(inv_vpn),
    .flush(flush)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  kind;
    logic        hit;
    logic        fault;
    logic [31:0] pa;
  } vec_t;

  // pages 0x10..0x13 carry protection codes 0..3, frame = page + 0x80000
  localparam vec_t VECS [13] = '{
    '{32'h0001_0ABC, 2'd0, 1'b1, 1'b1, 32'h8001_0ABC},
    '{32'h0001_0ABC, 2'd1, 1'b1, 1'b1, 32'h8001_0ABC},
    '{32'h0001_0ABC, 2'd2, 1'b1, 1'b1, 32'h8001_0ABC},
    '{32'h0001_1ABC, 2'd0, 1'b1, 1'b0, 32'h8001_1ABC},
    '{32'h0001_1ABC, 2'd1, 1'b1, 1'b1, 32'h8001_1ABC},
    '{32'h0001_1ABC, 2'd2, 1'b1, 1'b1, 32'h8001_1ABC},
    '{32'h0001_2ABC, 2'd0, 1'b1, 1'b0, 32'h8001_2ABC},
    '{32'h0001_2ABC, 2'd1, 1'b1, 1'b0, 32'h8001_2ABC},
    '{32'h0001_2ABC, 2'd2, 1'b1, 1'b1, 32'h8001_2ABC},
    '{32'h0001_3ABC, 2'd0, 1'b1, 1'b0, 32'h8001_3ABC},
    '{32'h0001_3ABC, 2'd1, 1'b1, 1'b1, 32'h8001_3ABC},
    '{32'h0001_3ABC, 2'd2, 1'b1, 1'b0, 32'h8001_3ABC},
    '{32'h0009_9ABC, 2'd0, 1'b0, 1'b0, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    lk_valid = 1'b0; lk_vaddr = '0; lk_kind = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_pfn = '0; fill_prot = '0;
    inv_valid = 1'b0; inv_vpn = '0; flush = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    clear_in();
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [1:0] prot);
    @(negedge clk);
    clear_in();
    fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_prot = prot;
    rr = (rr + 1) % 16;
  endtask

  task automatic invalidate(input logic [19:0] vpn);
    @(negedge clk);
    clear_in();
    inv_valid = 1'b1; inv_vpn = vpn;
  endtask

  // drive a lookup and sample the combinational result before the next edge
  task automatic look(input logic [31:0] va, input logic [1:0] kind);
    @(negedge clk);
    clear_in();
    lk_valid = 1'b1; lk_vaddr = va; lk_kind = kind;
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_in();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: empty after reset
    look(32'h0000_0123, 2'd0);
    check("R3 reset miss", {31'd0, lk_miss}, 32'd1);
    check("R3 reset hit", {31'd0, lk_hit}, 32'd0);
    check("R2 reset paddr", lk_paddr, 32'd0);

    // R7 R8: four refills into empty slots
    for (int p = 0; p < 4; p++) fill(20'h00010 + 20'(p), 20'h80010 + 20'(p), 2'(p));

    // R1 R2 R4: protection matrix walk
    for (int i = 0; i < 13; i++) begin
      look(VECS[i].va, VECS[i].kind);
      check("R1 hit", {31'd0, lk_hit}, {31'd0, VECS[i].hit});
      check("R1 miss", {31'd0, lk_miss}, {31'd0, !VECS[i].hit});
      check("R4 fault", {31'd0, lk_fault}, {31'd0, VECS[i].fault});
      check("R2 paddr", lk_paddr, VECS[i].pa);
    end

    // R6: page 0x10 only ever faulted
    look(32'h0001_0000, 2'd0);
    check("R6 ref after faults", {31'd0, lk_ref}, 32'd0);
    check("R6 mod after faults", {31'd0, lk_mod}, 32'd0);
    // R5: read-only page read once, write faulted
    look(32'h0001_1000, 2'd0);
    check("R5 ref set by read", {31'd0, lk_ref}, 32'd1);
    check("R5 mod kept by read", {31'd0, lk_mod}, 32'd0);
    look(32'h0001_2000, 2'd0);
    check("R5 mod set by write", {31'd0, lk_mod}, 32'd1);
    look(32'h0001_3000, 2'd0);
    check("R5 execute no mod", {31'd0, lk_mod}, 32'd0);

    // R12 R7: fresh entry shows pre-update flags
    fill(20'h00020, 20'h12345, 2'd2);
    look(32'h0002_0004, 2'd0);
    check("R7 fresh ref", {31'd0, lk_ref}, 32'd0);
    check("R7 fresh paddr", lk_paddr, 32'h1234_5004);
    look(32'h0002_0004, 2'd1);
    check("R12 ref before write", {31'd0, lk_ref}, 32'd1);
    check("R12 mod before write", {31'd0, lk_mod}, 32'd0);
    look(32'h0002_0004, 2'd0);
    check("R12 mod after write", {31'd0, lk_mod}, 32'd1);
    look(32'h0002_0004, 2'd3);
    check("R4 reserved kind faults", {31'd0, lk_fault}, 32'd1);

    // R10: invalidate one page
    invalidate(20'h00011);
    look(32'h0001_1000, 2'd0);
    check("R10 target gone", {31'd0, lk_hit}, 32'd0);
    look(32'h0001_2000, 2'd0);
    check("R10 neighbour kept", {31'd0, lk_hit}, 32'd1);

    // R11: flush, and flush beats refill
    @(negedge clk);
    clear_in();
    flush = 1'b1;
    fill_valid = 1'b1; fill_vpn = 20'h00077; fill_pfn = 20'h00077; fill_prot = 2'd1;
    look(32'h0001_2000, 2'd0);
    check("R11 flushed entry", {31'd0, lk_hit}, 32'd0);
    look(32'h0007_7000, 2'd0);
    check("R11 refill discarded", {31'd0, lk_hit}, 32'd0);

    // R8 R9: fill all 16 slots, then evict by pointer
    begin
      int rr0;
      int ev1;
      int ev2;
      int ev3;
      for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 2'd1);
      rr0 = rr;
      fill(20'h00300, 20'h00400, 2'd1);
      ev1 = rr0;
      fill(20'h00301, 20'h00401, 2'd1);
      ev2 = (rr0 + 1) % 16;
      invalidate(20'h0010A);
      fill(20'h00302, 20'h00402, 2'd1);
      ev3 = rr;
      fill(20'h00303, 20'h00403, 2'd1);
      look({20'h00100 + 20'(ev1), 12'h0}, 2'd0);
      check("R9 first eviction", {31'd0, lk_hit}, 32'd0);
      look({20'h00100 + 20'(ev2), 12'h0}, 2'd0);
      check("R9 second eviction", {31'd0, lk_hit}, 32'd0);
      look({20'h00100 + 20'((ev2 + 1) % 16), 12'h0}, 2'd0);
      check("R9 next slot kept", {31'd0, lk_hit}, 32'd1);
      look({20'h00100 + 20'(ev3), 12'h0}, 2'd0);
      check("R9 pointer advanced by free-slot refill", {31'd0, lk_hit}, 32'd0);
      look(32'h0030_2010, 2'd0);
      check("R8 refill took free slot", lk_paddr, 32'h0040_2010);
      look(32'h0030_0010, 2'd0);
      check("R9 new page hits", lk_paddr, 32'h0040_0010);
      look(32'h0030_3010, 2'd0);
      check("R9 last page hits", lk_paddr, 32'h0040_3010);
    end

    idle();
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule